// File: doc/BRIEF.md
# Banked data memory address decoder

This block sits between the operand fetch of a small 8-bit core and its 4096-byte data space. Each cycle it builds a 12-bit data address in one of three ways. It can join a 4-bit bank number to an 8-bit operand offset. It can fold the offset into a fixed window made of the bottom of bank 0 and the top of bank 15. Or it can take a flat 12-bit pointer as the whole address.

The address then falls into one of four classes: general-purpose RAM at the bottom of the map, the special-function register window at 0xF80 to 0xFFF, unimplemented space, or the boot-RAM banks 4 and 5 while they are locked. The block holds the general-purpose RAM itself. It strobes an external port for special-function register accesses and registers the selected read data one cycle later. Locked and unimplemented locations read as zero and drop writes.

Top module: `bank_mem_decoder`

## Requirements
- R1: After reset `bsr_o` is 0x00. Loading the bank register keeps only bits 3:0 of `bsr_wdata_i`, so `bsr_o[7:4]` always reads zero.
- R2: With `ind_i`=0 and `acc_i`=0, `addr_o` equals {bank register[3:0], `off_i`[7:0]}, using the bank value loaded on an earlier edge.
- R3: With `ind_i`=0 and `acc_i`=1, offsets 0x00-0x7F map to 0x000-0x07F and offsets 0x80-0xFF map to 0xF80-0xFFF, whatever the bank register holds.
- R4: With `ind_i`=1, `addr_o` equals `fsr_i`. This takes priority over `acc_i` and the bank register.
- R5: A write with `wr_i`=1 to general-purpose RAM (0x000-0x5FF) is stored at that clock edge. A read with `rd_i`=1 presents the stored byte on `rdata_o` after the next edge and not before. `rdata_o` holds its value while `rd_i`=0.
- R6: Addresses 0x600-0xF7F are unimplemented. They read as 0x00, writes to them change nothing, and they raise no SFR strobe.
- R7: For addresses 0xF80-0xFFF, `sfr_addr_o` carries address bits 6:0, and `sfr_we_o`/`sfr_re_o` follow `wr_i`/`rd_i` in the same cycle. A read registers `sfr_rdata_i` into `rdata_o` on the next edge.
- R8: While `prgm_lock_i`=1, addresses 0x400-0x5FF read as 0x00 and writes to them are dropped. Their earlier contents return once the lock clears, and 0x3FF stays readable.
- R9: Reset leaves the general-purpose RAM contents intact and clears `rdata_o` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bsr_we_i | input | 1 | Load strobe for the bank register |
| bsr_wdata_i | input | 8 | Bank register load value |
| bsr_o | output | 8 | Bank register readback, upper nibble zero |
| ind_i | input | 1 | Indirect access through `fsr_i` |
| acc_i | input | 1 | Access-bank mapping of the offset |
| off_i | input | 8 | Operand offset |
| fsr_i | input | 12 | Flat pointer for indirect access |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wdata_i | input | 8 | Write data |
| prgm_lock_i | input | 1 | Lock out boot-RAM banks 4 and 5 |
| addr_o | output | 12 | Effective data address |
| sfr_addr_o | output | 7 | Index into the SFR window |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_re_o | output | 1 | SFR read strobe |
| sfr_rdata_i | input | 8 | SFR read data, valid in the strobe cycle |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench uses the default parameters: 1536 bytes of general-purpose RAM, the SFR window based at 0xF80, and boot lockout enabled over 0x400-0x5FF. With these values every region edge can be reached with real addresses: the last RAM byte 0x5FF and the first hole byte 0x600, the last hole byte 0xF7F and the first SFR 0xF80, and 0x3FF just below the lockable banks. The same values let a locked write be followed by an unlocked read-back of the earlier byte. A table of address-formation vectors covers banked, access-bank and indirect modes, including the 0x7F/0x80 split of the access bank.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [1:0] {
    RG_GPR  = 2'd0,
    RG_SFR  = 2'd1,
    RG_HOLE = 2'd2,
    RG_LOCK = 2'd3
  } region_e;
endpackage

// File: rtl/bmd_addr_gen.sv
module bmd_addr_gen #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 8,
  localparam int BANK_W = ADDR_W - OFF_W
) (
  input  logic              ind_i,
  input  logic              acc_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] fsr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    if (ind_i)      addr_o = fsr_i;
    else if (acc_i) addr_o = {{BANK_W{off_i[OFF_W-1]}}, off_i}; // low half -> bank 0, high half -> top bank
    else            addr_o = {bank_i, off_i};
  end
endmodule

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
  import bmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int GPR_BYTES = 1536,
  parameter int SFR_BASE  = 'hF80,
  parameter bit BOOT_EN   = 1'b1,
  parameter int BOOT_LO   = 'h400,
  parameter int BOOT_HI   = 'h5FF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lock_i,
  output region_e           region_o
);
  logic in_boot;

  generate
    if (BOOT_EN) begin : g_boot
      assign in_boot = lock_i && (int'(addr_i) >= BOOT_LO) && (int'(addr_i) <= BOOT_HI);
    end else begin : g_noboot
      logic unused_lock;
      assign unused_lock = lock_i;
      assign in_boot = 1'b0;
    end
  endgenerate

  always_comb begin
    if (int'(addr_i) >= SFR_BASE)      region_o = RG_SFR;
    else if (int'(addr_i) < GPR_BYTES) region_o = in_boot ? RG_LOCK : RG_GPR;
    else                               region_o = RG_HOLE;
  end
endmodule

// File: rtl/bmd_gpr_ram.sv
module bmd_gpr_ram #(
  parameter int DEPTH  = 1536,
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // no reset: contents survive reset
  always_ff @(posedge clk_i) begin
    if (we_i && int'(idx_i) < DEPTH) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = (int'(idx_i) < DEPTH) ? mem[idx_i] : '0;
endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 8,
  parameter int GPR_BYTES = 1536,
  parameter int SFR_BASE  = 'hF80,
  parameter bit BOOT_EN   = 1'b1,
  parameter int BOOT_LO   = 'h400,
  parameter int BOOT_HI   = 'h5FF,
  localparam int BANK_W   = ADDR_W - OFF_W,
  localparam int SFR_IW   = $clog2((1 << ADDR_W) - SFR_BASE),
  localparam int GIW      = $clog2(GPR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bsr_we_i,
  input  logic [OFF_W-1:0]  bsr_wdata_i,
  output logic [OFF_W-1:0]  bsr_o,
  input  logic              ind_i,
  input  logic              acc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] fsr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              prgm_lock_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SFR_IW-1:0] sfr_addr_o,
  output logic              sfr_we_o,
  output logic              sfr_re_o,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [BANK_W-1:0] bsr_q;
  logic [ADDR_W-1:0] eff_addr;
  region_e           region;
  logic              gpr_we;
  logic [DATA_W-1:0] ram_rdata;
  logic              unused_bsr_hi;

  assign unused_bsr_hi = ^bsr_wdata_i[OFF_W-1:BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bsr_q <= '0;
    else if (bsr_we_i) bsr_q <= bsr_wdata_i[BANK_W-1:0];
  end
  assign bsr_o = {{(OFF_W-BANK_W){1'b0}}, bsr_q};

  bmd_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .ind_i  (ind_i),
    .acc_i  (acc_i),
    .bank_i (bsr_q),
    .off_i  (off_i),
    .fsr_i  (fsr_i),
    .addr_o (eff_addr)
  );

  bmd_region_decode #(
    .ADDR_W(ADDR_W), .GPR_BYTES(GPR_BYTES), .SFR_BASE(SFR_BASE),
    .BOOT_EN(BOOT_EN), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)
  ) u_dec (
    .addr_i   (eff_addr),
    .lock_i   (prgm_lock_i),
    .region_o (region)
  );

  assign gpr_we     = wr_i && (region == RG_GPR);
  assign sfr_we_o   = wr_i && (region == RG_SFR);
  assign sfr_re_o   = rd_i && (region == RG_SFR);
  assign sfr_addr_o = eff_addr[SFR_IW-1:0];
  assign addr_o     = eff_addr;

  bmd_gpr_ram #(.DEPTH(GPR_BYTES), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (gpr_we),
    .idx_i   (eff_addr[GIW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) begin
      unique case (region)
        RG_GPR:  rdata_o <= ram_rdata;
        RG_SFR:  rdata_o <= sfr_rdata_i;
        default: rdata_o <= '0;
      endcase
    end
  end

  p_bsr_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_we_i |=> bsr_o == {{(OFF_W-BANK_W){1'b0}}, $past(bsr_wdata_i[BANK_W-1:0])});

  p_indirect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_i |-> addr_o == fsr_i);

  p_hole_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && region == RG_HOLE) |=> rdata_o == '0);

  p_one_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sfr_we_o, gpr_we}));

  p_sfr_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_re_o || sfr_we_o) |-> int'(eff_addr) >= SFR_BASE);

  p_lock_no_we_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BOOT_EN && prgm_lock_i && int'(eff_addr) >= BOOT_LO && int'(eff_addr) <= BOOT_HI) |-> !gpr_we);
endmodule

// File: tb/bank_mem_decoder_test.sv
module bank_mem_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsr_we = 1'b0;
  logic [7:0]  bsr_wdata = '0;
  logic [7:0]  bsr;
  logic        ind = 1'b0, acc = 1'b0;
  logic [7:0]  off = '0;
  logic [11:0] fsr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        lock = 1'b0;
  logic [11:0] addr;
  logic [6:0]  sfr_addr;
  logic        sfr_we, sfr_re;
  logic [7:0]  sfr_rdata = 8'h3C;
  logic [7:0]  rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_mem_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .bsr_we_i(bsr_we), .bsr_wdata_i(bsr_wdata), .bsr_o(bsr),
    .ind_i(ind), .acc_i(acc), .off_i(off), .fsr_i(fsr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .prgm_lock_i(lock), .addr_o(addr), .sfr_addr_o(sfr_addr),
    .sfr_we_o(sfr_we), .sfr_re_o(sfr_re), .sfr_rdata_i(sfr_rdata), .rdata_o(rdata)
  );

  typedef struct packed {
    logic        ind;
    logic        acc;
    logic [3:0]  bank;
    logic [7:0]  off;
    logic [11:0] fsr;
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 4'h3, 8'h45, 12'h000, 12'h345},
    '{1'b0, 1'b0, 4'hF, 8'hFF, 12'h000, 12'hFFF},
    '{1'b0, 1'b1, 4'h7, 8'h10, 12'h000, 12'h010},
    '{1'b0, 1'b1, 4'h7, 8'h7F, 12'h000, 12'h07F},
    '{1'b0, 1'b1, 4'h2, 8'h80, 12'h000, 12'hF80},
    '{1'b0, 1'b1, 4'h2, 8'hC3, 12'h000, 12'hFC3},
    '{1'b1, 1'b0, 4'h9, 8'h12, 12'hABC, 12'hABC},
    '{1'b1, 1'b1, 4'h9, 8'h90, 12'h123, 12'h123}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic set_bank(input logic [7:0] v);
    @(negedge clk); bsr_we = 1'b1; bsr_wdata = v;
    @(negedge clk); bsr_we = 1'b0;
  endtask

  task automatic wr_ptr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); ind = 1'b1; acc = 1'b0; fsr = a; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_ptr(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); ind = 1'b1; acc = 1'b0; fsr = a; rd = 1'b1;
    @(posedge clk); #1 chk(rdata, exp, tag);
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(bsr, 8'h00, "R1 bank reset");
    chk(rdata, 8'h00, "R9 rdata reset");
    @(negedge clk); rst_n = 1'b1;

    set_bank(8'hFF);
    #1 chk(bsr, 8'h0F, "R1 upper nibble zero");

    // address formation table
    for (int i = 0; i < 8; i++) begin
      set_bank({4'h0, VEC[i].bank});
      ind = VEC[i].ind; acc = VEC[i].acc; off = VEC[i].off; fsr = VEC[i].fsr;
      #1 chk(addr, VEC[i].exp, VEC[i].ind ? "R4 indirect" : (VEC[i].acc ? "R3 access" : "R2 banked"));
    end

    // R5 write/read with one-cycle latency
    wr_ptr(12'h345, 8'hA5);
    @(negedge clk); ind = 1'b1; fsr = 12'h345; rd = 1'b1;
    #1 chk(rdata, 8'h00, "R5 not before edge");
    @(posedge clk); #1 chk(rdata, 8'hA5, "R5 read back");
    @(negedge clk); rd = 1'b0; fsr = 12'h000;
    @(posedge clk); #1 chk(rdata, 8'hA5, "R5 hold while idle");

    // access-bank write seen through banked read of bank 0
    @(negedge clk); ind = 1'b0; acc = 1'b1; off = 8'h05; wr = 1'b1; wdata = 8'h6E;
    @(negedge clk); wr = 1'b0;
    set_bank(8'h00);
    @(negedge clk); acc = 1'b0; off = 8'h05; rd = 1'b1;
    @(posedge clk); #1 chk(rdata, 8'h6E, "R3 access bank aliases bank 0");
    @(negedge clk); rd = 1'b0;

    // R6 unimplemented space
    @(negedge clk); ind = 1'b1; fsr = 12'h700; wr = 1'b1; wdata = 8'h5A;
    #1 chk(sfr_we, 1'b0, "R6 no sfr strobe");
    @(negedge clk); wr = 1'b0;
    rd_ptr(12'h700, 8'h00, "R6 hole reads zero");
    wr_ptr(12'h5FF, 8'hC7);
    rd_ptr(12'h5FF, 8'hC7, "R5 last ram byte");
    rd_ptr(12'h600, 8'h00, "R6 first hole byte");
    rd_ptr(12'hF7F, 8'h00, "R6 last hole byte");

    // R7 SFR window
    @(negedge clk); ind = 1'b1; fsr = 12'hF85; wr = 1'b1; wdata = 8'h11;
    #1 chk(sfr_we, 1'b1, "R7 sfr write strobe");
    chk(sfr_addr, 7'h05, "R7 sfr index");
    @(negedge clk); wr = 1'b0; fsr = 12'hF80; rd = 1'b1;
    #1 chk(sfr_re, 1'b1, "R7 sfr read strobe at base");
    @(posedge clk); #1 chk(rdata, 8'h3C, "R7 sfr read data");
    @(negedge clk); rd = 1'b0;
    #1 chk(sfr_re, 1'b0, "R7 no strobe without rd");

    // R8 boot lockout
    wr_ptr(12'h480, 8'h77);
    wr_ptr(12'h3FF, 8'h42);
    @(negedge clk); lock = 1'b1;
    rd_ptr(12'h480, 8'h00, "R8 locked read zero");
    rd_ptr(12'h5FF, 8'h00, "R8 locked top byte");
    rd_ptr(12'h3FF, 8'h42, "R8 below lock readable");
    wr_ptr(12'h480, 8'h11);
    @(negedge clk); lock = 1'b0;
    rd_ptr(12'h480, 8'h77, "R8 locked write dropped");

    // R9 ram survives reset
    wr_ptr(12'h100, 8'h99);
    @(negedge clk); rst_n = 1'b0;
    #1 chk(rdata, 8'h00, "R9 rdata clears");
    set_bank(8'h00);
    @(negedge clk); rst_n = 1'b1;
    rd_ptr(12'h100, 8'h99, "R9 ram kept");

    finish_run();
  end
endmodule